// File: doc/BRIEF.md
# SIMT Reconvergence Stack

This block holds the divergence and reconvergence state of one warp of threads that share a single program counter. Each stack slot records a program counter, a per-lane active mask, the reconvergence PC for that path, a call depth and a cycle stamp. The stamp records when the slot was turned into a reconvergence point. The slot at the top index names the PC and the lanes that issue next.

A launch clears the whole stack and seeds slot 0 with a start PC and a lane mask. After a branch executes, an update request supplies three inputs: a done flag per lane, a next PC per lane, and the branch's immediate post-dominator PC. The controller then walks the top slot's lanes from the highest index down. It takes one group of lanes that share a next PC per clock. It pushes the groups that still have work to do. It drops groups that arrive at a reconvergence point, which pops the stack back to the waiting entry. While it runs, a busy flag blocks further requests, and a one-cycle done pulse marks the end of the update.

PC value 0 is reserved as an internal "no group yet" marker. Next PCs of live lanes must be non-zero.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the top index is 0. The top PC and top reconvergence PC are all-ones. The top mask, call depth and stamp are 0. Busy and error are low.
- R2: A launch request takes effect at the next edge and overrides any update in progress. Slot 0 then holds the start PC, call depth 1, the given mask and an all-ones reconvergence PC. The top index is 0 and the error flag is cleared.
- R3: Groups are formed in descending lane order. The highest-numbered live lane picks the group's PC, and every other live lane with the same next PC joins that group. Kept groups are written at consecutive slots, so the group holding the lowest-numbered lanes ends on top.
- R4: Lanes flagged done leave the mask. If every active lane of the top slot is done, the top slot becomes PC 0 with an empty mask at the same index, and it keeps its reconvergence PC.
- R5: A group whose PC equals the top slot's reconvergence PC is not pushed. If every group is dropped, the top index falls by one.
- R6: On the first group that leaves other lanes pending, the warp counts as diverged. If the branch reconvergence PC differs from the top's, the old top slot's PC is replaced by the branch reconvergence PC and its stamp takes the value of cycle_i. Every group pushed after divergence gets call depth 0 and the branch reconvergence PC. If the two reconvergence PCs are equal, no slot is rewritten.
- R7: Once diverged, a group whose PC equals the branch reconvergence PC is not pushed.
- R8: When all live lanes share one PC, the top slot is updated in place. It takes the new PC and mask, keeps its reconvergence PC and call depth, and the top index does not change.
- R9: An accepted update keeps busy high for exactly one cycle per group formed. upd_done_o pulses in the cycle busy falls. An update request while busy is ignored.
- R10: An update request while the top mask is empty sets the error flag and changes nothing. An update that drops every group while the top index is 0 sets the error flag and leaves the top index at 0. The error flag stays set until the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_i | input | 1 | Clear the stack and seed slot 0 |
| launch_pc_i | input | PC_W | Start PC for a launch |
| launch_mask_i | input | WARP_SZ | Active lanes for a launch |
| upd_i | input | 1 | Update request, accepted when idle |
| upd_done_mask_i | input | WARP_SZ | Per-lane finished flags |
| upd_next_pc_i | input | WARP_SZ*PC_W | Next PC per lane, lane n in bits n*PC_W upward |
| upd_rpc_i | input | PC_W | Reconvergence PC of the branch |
| cycle_i | input | STAMP_W | Free-running cycle count used for stamps |
| busy_o | output | 1 | Update in progress; top outputs are not valid |
| upd_done_o | output | 1 | One-cycle pulse when an update ends |
| err_o | output | 1 | Sticky error flag |
| top_idx_o | output | clog2(2*WARP_SZ) | Current top index |
| top_pc_o | output | PC_W | PC of the top slot |
| top_mask_o | output | WARP_SZ | Active mask of the top slot |
| top_rpc_o | output | PC_W | Reconvergence PC of the top slot |
| top_cd_o | output | CD_W | Call depth of the top slot |
| top_stamp_o | output | STAMP_W | Divergence stamp of the top slot |

## Verification
A launch shows on the top outputs one edge after it is sampled. A rejected update raises the error flag at that same next edge. An accepted update keeps busy high for as many cycles as it forms groups, and its results appear together with the done pulse at the edge where busy falls. The bench drives inputs on falling edges and counts the falling edges at which busy is high. It compares that count with the group count from its own stack model, then checks the done pulse and every top output at the first falling edge with busy low. This means no result is sampled while the stack is half written.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } upd_state_e;
endpackage

// File: rtl/simt_group_pick.sv
module simt_group_pick #(
   parameter int WARP_SZ = 8,
   parameter int PC_W    = 16
) (
   input  logic [WARP_SZ-1:0]      work_i,
   input  logic [WARP_SZ*PC_W-1:0] next_pc_i,
   output logic [PC_W-1:0]         grp_pc_o,
   output logic [WARP_SZ-1:0]      grp_mask_o
);
   logic [PC_W-1:0] lead_pc;

   // ascending walk: the highest live lane writes last and wins
   always_comb begin
      lead_pc = '0;
      for (int l = 0; l < WARP_SZ; l++) begin
         if (work_i[l]) lead_pc = next_pc_i[l*PC_W +: PC_W];
      end
   end

   for (genvar g = 0; g < WARP_SZ; g++) begin : g_lane
      assign grp_mask_o[g] = work_i[g] && (next_pc_i[g*PC_W +: PC_W] == lead_pc);
   end

   assign grp_pc_o = lead_pc;
endmodule

// File: rtl/simt_stack_mem.sv
module simt_stack_mem #(
   parameter int WARP_SZ  = 8,
   parameter int PC_W     = 16,
   parameter int CD_W     = 4,
   parameter int STAMP_W  = 16,
   parameter bit STAMP_EN = 1'b1,
   parameter int DEPTH    = 16,
   parameter int ENT_W    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_en_i,
   input  logic [PC_W-1:0]    ld_pc_i,
   input  logic [WARP_SZ-1:0] ld_mask_i,
   input  logic               rw_en_i,
   input  logic [ENT_W-1:0]   rw_idx_i,
   input  logic [PC_W-1:0]    rw_pc_i,
   input  logic [STAMP_W-1:0] rw_stamp_i,
   input  logic               ps_en_i,
   input  logic [ENT_W-1:0]   ps_idx_i,
   input  logic [PC_W-1:0]    ps_pc_i,
   input  logic [WARP_SZ-1:0] ps_mask_i,
   input  logic [PC_W-1:0]    ps_rpc_i,
   input  logic               ps_cd_clr_i,
   input  logic               sc_en_i,
   input  logic [ENT_W-1:0]   sc_idx_i,
   input  logic [ENT_W-1:0]   rd_idx_i,
   output logic [PC_W-1:0]    rd_pc_o,
   output logic [WARP_SZ-1:0] rd_mask_o,
   output logic [PC_W-1:0]    rd_rpc_o,
   output logic [CD_W-1:0]    rd_cd_o,
   output logic [STAMP_W-1:0] rd_stamp_o
);
   logic [PC_W-1:0]    pc_q   [DEPTH];
   logic [WARP_SZ-1:0] mask_q [DEPTH];
   logic [PC_W-1:0]    rpc_q  [DEPTH];
   logic [CD_W-1:0]    cd_q   [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) begin
            pc_q[e]   <= '1;
            mask_q[e] <= '0;
            rpc_q[e]  <= '1;
            cd_q[e]   <= '0;
         end
      end else if (ld_en_i) begin
         for (int e = 0; e < DEPTH; e++) begin
            pc_q[e]   <= (e == 0) ? ld_pc_i : '1;
            mask_q[e] <= (e == 0) ? ld_mask_i : '0;
            rpc_q[e]  <= '1;
            cd_q[e]   <= (e == 0) ? CD_W'(1) : '0;
         end
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (rw_en_i && rw_idx_i == ENT_W'(e)) pc_q[e] <= rw_pc_i;
            if (ps_en_i && ps_idx_i == ENT_W'(e)) begin
               pc_q[e]   <= ps_pc_i;
               mask_q[e] <= ps_mask_i;
               rpc_q[e]  <= ps_rpc_i;
               if (ps_cd_clr_i) cd_q[e] <= '0;
            end
         end
      end
   end

   assign rd_pc_o   = pc_q[rd_idx_i];
   assign rd_mask_o = mask_q[rd_idx_i];
   assign rd_rpc_o  = rpc_q[rd_idx_i];
   assign rd_cd_o   = cd_q[rd_idx_i];

   if (STAMP_EN) begin : g_stamp
      logic [STAMP_W-1:0] st_q [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) st_q[e] <= '0;
         end else if (ld_en_i) begin
            for (int e = 0; e < DEPTH; e++) st_q[e] <= '0;
         end else begin
            for (int e = 0; e < DEPTH; e++) begin
               if (rw_en_i && rw_idx_i == ENT_W'(e)) st_q[e] <= rw_stamp_i;
               if (sc_en_i && sc_idx_i == ENT_W'(e)) st_q[e] <= '0;
            end
         end
      end
      assign rd_stamp_o = st_q[rd_idx_i];
   end else begin : g_nostamp
      logic unused_stamp_in;
      assign unused_stamp_in = ^{rw_stamp_i, sc_en_i, sc_idx_i};
      assign rd_stamp_o = '0;
   end

   // R6: the reconvergence rewrite and the push never target the same slot
   assert_rewrite_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rw_en_i && ps_en_i && !ld_en_i) |-> (rw_idx_i != ps_idx_i));
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
   import simt_stack_pkg::*;
#(
   parameter int WARP_SZ  = 8,
   parameter int PC_W     = 16,
   parameter int CD_W     = 4,
   parameter int STAMP_W  = 16,
   parameter bit STAMP_EN = 1'b1,
   localparam int DEPTH   = 2 * WARP_SZ,
   localparam int ENT_W   = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    launch_i,
   input  logic [PC_W-1:0]         launch_pc_i,
   input  logic [WARP_SZ-1:0]      launch_mask_i,
   input  logic                    upd_i,
   input  logic [WARP_SZ-1:0]      upd_done_mask_i,
   input  logic [WARP_SZ*PC_W-1:0] upd_next_pc_i,
   input  logic [PC_W-1:0]         upd_rpc_i,
   input  logic [STAMP_W-1:0]      cycle_i,
   output logic                    busy_o,
   output logic                    upd_done_o,
   output logic                    err_o,
   output logic [ENT_W-1:0]        top_idx_o,
   output logic [PC_W-1:0]         top_pc_o,
   output logic [WARP_SZ-1:0]      top_mask_o,
   output logic [PC_W-1:0]         top_rpc_o,
   output logic [CD_W-1:0]         top_cd_o,
   output logic [STAMP_W-1:0]      top_stamp_o
);
   localparam int IDX_W = ENT_W + 1;
   localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

   if (WARP_SZ < 2 || WARP_SZ > 32) begin : g_bad_warp
      $error("WARP_SZ must lie in 2..32");
   end
   if (PC_W < 2 || CD_W < 1 || STAMP_W < 1) begin : g_bad_width
      $error("PC_W, CD_W and STAMP_W too narrow");
   end

   upd_state_e              state_q;
   logic [WARP_SZ-1:0]      work_q;
   logic [IDX_W-1:0]        wptr_q;
   logic                    div_q;
   logic [PC_W-1:0]         brpc_q, oldrpc_q;
   logic [WARP_SZ*PC_W-1:0] npc_q;
   logic [ENT_W-1:0]        top_q;
   logic                    err_q, done_q;

   logic [PC_W-1:0]    g_pc;
   logic [WARP_SZ-1:0] g_mask, rem;
   logic               running, accept, empty_top, last;
   logic               keep_a, split, rewr, div_n, keep_b, ovf;
   logic [IDX_W-1:0]   slot, wptr_n;
   logic               rw_en, ps_en, sc_en;

   simt_group_pick #(.WARP_SZ(WARP_SZ), .PC_W(PC_W)) u_pick (
      .work_i    (work_q),
      .next_pc_i (npc_q),
      .grp_pc_o  (g_pc),
      .grp_mask_o(g_mask)
   );

   always_comb begin
      running   = (state_q == ST_RUN) && !launch_i;
      accept    = upd_i && (state_q == ST_IDLE) && !launch_i;
      empty_top = ~|top_mask_o;
      rem       = work_q & ~g_mask;
      last      = ~|rem;
      keep_a    = (g_pc != oldrpc_q);
      split     = keep_a && !last && !div_q;
      rewr      = split && (brpc_q != oldrpc_q);
      slot      = rewr ? wptr_q + 1'b1 : wptr_q;
      div_n     = div_q | split;
      keep_b    = keep_a && !(div_n && g_pc == brpc_q);
      wptr_n    = keep_b ? slot + 1'b1 : slot;
      rw_en     = running && rewr && (wptr_q < DEPTH_I);
      sc_en     = running && rewr && (slot < DEPTH_I);
      ps_en     = running && keep_b && (slot < DEPTH_I);
      ovf       = running && ((rewr && slot >= DEPTH_I) || (keep_b && slot >= DEPTH_I));
   end

   simt_stack_mem #(
      .WARP_SZ(WARP_SZ), .PC_W(PC_W), .CD_W(CD_W), .STAMP_W(STAMP_W),
      .STAMP_EN(STAMP_EN), .DEPTH(DEPTH), .ENT_W(ENT_W)
   ) u_mem (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_en_i    (launch_i),
      .ld_pc_i    (launch_pc_i),
      .ld_mask_i  (launch_mask_i),
      .rw_en_i    (rw_en),
      .rw_idx_i   (wptr_q[ENT_W-1:0]),
      .rw_pc_i    (brpc_q),
      .rw_stamp_i (cycle_i),
      .ps_en_i    (ps_en),
      .ps_idx_i   (slot[ENT_W-1:0]),
      .ps_pc_i    (g_pc),
      .ps_mask_i  (g_mask),
      .ps_rpc_i   (div_n ? brpc_q : oldrpc_q),
      .ps_cd_clr_i(div_n),
      .sc_en_i    (sc_en),
      .sc_idx_i   (slot[ENT_W-1:0]),
      .rd_idx_i   (top_q),
      .rd_pc_o    (top_pc_o),
      .rd_mask_o  (top_mask_o),
      .rd_rpc_o   (top_rpc_o),
      .rd_cd_o    (top_cd_o),
      .rd_stamp_o (top_stamp_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         work_q   <= '0;
         wptr_q   <= '0;
         div_q    <= 1'b0;
         brpc_q   <= '0;
         oldrpc_q <= '0;
         npc_q    <= '0;
         top_q    <= '0;
         err_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (launch_i) begin
            state_q <= ST_IDLE;
            top_q   <= '0;
            err_q   <= 1'b0;
            div_q   <= 1'b0;
            work_q  <= '0;
         end else if (state_q == ST_IDLE) begin
            if (accept) begin
               if (empty_top) begin
                  err_q <= 1'b1;
               end else begin
                  state_q  <= ST_RUN;
                  work_q   <= top_mask_o & ~upd_done_mask_i;
                  wptr_q   <= {1'b0, top_q};
                  div_q    <= 1'b0;
                  brpc_q   <= upd_rpc_i;
                  oldrpc_q <= top_rpc_o;
                  npc_q    <= upd_next_pc_i;
               end
            end
         end else begin
            work_q <= rem;
            wptr_q <= wptr_n;
            div_q  <= div_n;
            if (ovf) err_q <= 1'b1;
            if (last) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
               if (wptr_n == '0) begin
                  err_q <= 1'b1;
                  top_q <= '0;
               end else if (wptr_n > DEPTH_I) begin
                  top_q <= ENT_W'(DEPTH - 1);
               end else begin
                  top_q <= ENT_W'(wptr_n - 1'b1);
               end
            end
         end
      end
   end

   assign busy_o     = (state_q == ST_RUN);
   assign upd_done_o = done_q;
   assign err_o      = err_q;
   assign top_idx_o  = top_q;

   assert_empty_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && empty_top) |=> (err_o && !busy_o));

   assert_launch_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      launch_i |=> (top_idx_o == '0 && top_cd_o == CD_W'(1) && !busy_o && !err_o
                    && top_pc_o == $past(launch_pc_i) && top_mask_o == $past(launch_mask_i)));

   assert_done_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && !$past(launch_i)) |-> upd_done_o);

   assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && upd_i && !launch_i) |=> $stable(npc_q));

   assert_group_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (((g_mask & ~work_q) == '0) && ((|work_q) == (|g_mask))));
endmodule

// File: tb/simt_reconv_stack_test.sv
`timescale 1ns/1ps
module simt_reconv_stack_test;
   localparam int W  = 8;
   localparam int PW = 16;
   localparam int D  = 2 * W;

   typedef struct packed {
      logic        op;     // 0 launch, 1 update
      logic [15:0] apc;    // launch PC or branch reconvergence PC
      logic [7:0]  amask;  // launch mask or done flags
      logic [7:0]  tgt;    // lanes that take tpc, the rest take fpc
      logic [15:0] tpc;
      logic [15:0] fpc;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 16'h0100, 8'hFF, 8'h00, 16'h0000, 16'h0000},
      '{1'b1, 16'h0400, 8'h00, 8'hF0, 16'h0200, 16'h0300},
      '{1'b1, 16'h0380, 8'h00, 8'h0C, 16'h0310, 16'h0320},
      '{1'b1, 16'h0400, 8'h00, 8'h00, 16'h0111, 16'h0380},
      '{1'b1, 16'h0400, 8'h00, 8'hFF, 16'h0380, 16'h0111},
      '{1'b1, 16'h0400, 8'h00, 8'h00, 16'h0111, 16'h0400},
      '{1'b1, 16'h0400, 8'h30, 8'hC0, 16'h0210, 16'h0220},
      '{1'b1, 16'h0400, 8'hC0, 8'h00, 16'h0111, 16'h0222},
      '{1'b1, 16'h0400, 8'h00, 8'hFF, 16'h0333, 16'h0333},
      '{1'b0, 16'h0500, 8'h0F, 8'h00, 16'h0000, 16'h0000},
      '{1'b1, 16'hFFFF, 8'h00, 8'h05, 16'h0600, 16'h0700},
      '{1'b1, 16'hFFFF, 8'h00, 8'hFF, 16'hFFFF, 16'h0111},
      '{1'b1, 16'hFFFF, 8'h00, 8'hFF, 16'hFFFF, 16'h0111},
      '{1'b0, 16'h0800, 8'hFF, 8'h00, 16'h0000, 16'h0000},
      '{1'b1, 16'h0880, 8'h00, 8'h81, 16'h0900, 16'h0880}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic launch_i = 1'b0, upd_i = 1'b0;
   logic [PW-1:0] launch_pc_i = '0, upd_rpc_i = '0;
   logic [W-1:0] launch_mask_i = '0, upd_done_mask_i = '0;
   logic [W*PW-1:0] upd_next_pc_i = '0;
   logic [15:0] cycle_i = '0;
   logic busy_o, upd_done_o, err_o;
   logic [3:0] top_idx_o;
   logic [PW-1:0] top_pc_o, top_rpc_o;
   logic [W-1:0] top_mask_o;
   logic [3:0] top_cd_o;
   logic [15:0] top_stamp_o;

   int n_chk = 0, n_bad = 0;

   logic [15:0] m_pc [D];
   logic [15:0] m_rpc [D];
   logic [7:0]  m_mask [D];
   logic [3:0]  m_cd [D];
   logic [15:0] m_st [D];
   int m_top;
   bit m_err;

   always #2.5 clk = ~clk;

   simt_reconv_stack uut (
      .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .launch_pc_i(launch_pc_i),
      .launch_mask_i(launch_mask_i), .upd_i(upd_i), .upd_done_mask_i(upd_done_mask_i),
      .upd_next_pc_i(upd_next_pc_i), .upd_rpc_i(upd_rpc_i), .cycle_i(cycle_i),
      .busy_o(busy_o), .upd_done_o(upd_done_o), .err_o(err_o), .top_idx_o(top_idx_o),
      .top_pc_o(top_pc_o), .top_mask_o(top_mask_o), .top_rpc_o(top_rpc_o),
      .top_cd_o(top_cd_o), .top_stamp_o(top_stamp_o)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic m_launch(input logic [15:0] pc, input logic [7:0] mask);
      for (int e = 0; e < D; e++) begin
         m_pc[e] = 16'hFFFF; m_rpc[e] = 16'hFFFF; m_mask[e] = 8'h00; m_cd[e] = 4'd0; m_st[e] = 16'h0;
      end
      m_pc[0] = pc; m_mask[0] = mask; m_cd[0] = 4'd1; m_top = 0; m_err = 1'b0;
   endtask

   task automatic m_update(input logic [7:0] done, input logic [W*PW-1:0] npc,
                           input logic [15:0] rpc, input logic [15:0] stamp, output int grp);
      logic [7:0] work, gm;
      logic [15:0] gpc, old;
      int wp, slot;
      bit dv;
      grp = 0;
      if (m_mask[m_top] == 8'h00) begin
         m_err = 1'b1;
         return;
      end
      work = m_mask[m_top]; old = m_rpc[m_top]; wp = m_top; dv = 1'b0;
      do begin
         gpc = 16'h0; gm = 8'h00;
         for (int l = W - 1; l >= 0; l--) begin
            if (work[l]) begin
               if (done[l]) work[l] = 1'b0;
               else if (gpc == 16'h0) begin gpc = npc[l*PW +: PW]; gm[l] = 1'b1; work[l] = 1'b0; end
               else if (gpc == npc[l*PW +: PW]) begin gm[l] = 1'b1; work[l] = 1'b0; end
            end
         end
         grp++;
         slot = wp;
         if (gpc != old) begin
            if (work != 8'h00 && !dv) begin
               dv = 1'b1;
               if (rpc != old) begin
                  m_pc[wp] = rpc; m_st[wp] = stamp; slot = wp + 1; m_st[slot] = 16'h0;
               end
            end
            if (!(dv && gpc == rpc)) begin
               m_pc[slot] = gpc; m_mask[slot] = gm;
               if (dv) begin m_cd[slot] = 4'd0; m_rpc[slot] = rpc; end
               else m_rpc[slot] = old;
               slot++;
            end
            wp = slot;
         end
      end while (work != 8'h00);
      if (wp == 0) begin m_err = 1'b1; m_top = 0; end
      else m_top = wp - 1;
   endtask

   task automatic cmp_top(input string req);
      chk(req, "top index", 32'(top_idx_o), 32'(m_top));
      chk(req, "top pc", 32'(top_pc_o), 32'(m_pc[m_top]));
      chk(req, "top mask", 32'(top_mask_o), 32'(m_mask[m_top]));
      chk(req, "top rpc", 32'(top_rpc_o), 32'(m_rpc[m_top]));
      chk(req, "top call depth", 32'(top_cd_o), 32'(m_cd[m_top]));
      chk(req, "top stamp", 32'(top_stamp_o), 32'(m_st[m_top]));
      chk(req, "error flag", 32'(err_o), 32'(m_err));
   endtask

   task automatic do_launch(input logic [15:0] pc, input logic [7:0] mask);
      @(negedge clk);
      launch_i = 1'b1; launch_pc_i = pc; launch_mask_i = mask;
      @(negedge clk);
      launch_i = 1'b0;
      m_launch(pc, mask);
   endtask

   // returns the number of falling edges with busy high and the done flag seen after
   task automatic do_update(input logic [7:0] done, input logic [W*PW-1:0] npc,
                            input logic [15:0] rpc, input logic [15:0] stamp,
                            input bit junk, output int cnt, output logic dn);
      @(negedge clk);
      upd_i = 1'b1; upd_done_mask_i = done; upd_next_pc_i = npc; upd_rpc_i = rpc; cycle_i = stamp;
      @(negedge clk);
      upd_i = 1'b0;
      cnt = 0;
      while (busy_o && cnt < 200) begin
         cnt++;
         if (junk && cnt == 1) begin
            upd_i = 1'b1; upd_done_mask_i = 8'hFF; upd_next_pc_i = {W{16'h0ABC}}; upd_rpc_i = 16'h0DEF;
         end else begin
            upd_i = 1'b0;
         end
         @(negedge clk);
      end
      upd_i = 1'b0;
      dn = upd_done_o;
   endtask

   function automatic logic [W*PW-1:0] split_pcs(input logic [7:0] tgt, input logic [15:0] tpc, input logic [15:0] fpc);
      logic [W*PW-1:0] v;
      for (int l = 0; l < W; l++) v[l*PW +: PW] = tgt[l] ? tpc : fpc;
      return v;
   endfunction

   function automatic string step_tag(input int i);
      case (i)
         0, 9, 13: return "R2 launch";
         1, 2:     return "R6 nested divergence";
         3, 4, 5:  return "R5 reconverge pop";
         6:        return "R8 single group in place";
         7:        return "R4 all lanes done";
         8:        return "R10 empty mask";
         10:       return "R6 equal rpc no rewrite";
         11:       return "R5 pop to slot 0";
         12:       return "R10 underflow";
         default:  return "R7 drop group at branch rpc";
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      int grp, cnt;
      logic dn;
      logic [W*PW-1:0] v;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "top index", 32'(top_idx_o), 32'd0);
      chk("R1", "top pc", 32'(top_pc_o), 32'hFFFF);
      chk("R1", "top rpc", 32'(top_rpc_o), 32'hFFFF);
      chk("R1", "top mask", 32'(top_mask_o), 32'd0);
      chk("R1", "top cd", 32'(top_cd_o), 32'd0);
      chk("R1", "top stamp", 32'(top_stamp_o), 32'd0);
      chk("R1", "busy", 32'(busy_o), 32'd0);
      chk("R1", "error", 32'(err_o), 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (!VECS[i].op) begin
            do_launch(VECS[i].apc, VECS[i].amask);
         end else begin
            v = split_pcs(VECS[i].tgt, VECS[i].tpc, VECS[i].fpc);
            m_update(VECS[i].amask, v, VECS[i].apc, 16'(i * 17 + 3), grp);
            do_update(VECS[i].amask, v, VECS[i].apc, 16'(i * 17 + 3), 1'b0, cnt, dn);
            chk("R9", "busy cycles", 32'(cnt), 32'(grp));
            chk("R9", "done pulse", 32'(dn), 32'(grp > 0));
         end
         cmp_top(step_tag(i));
      end

      // R3: three groups, highest lane first; junk request while busy (R9)
      do_launch(16'h0100, 8'hFF);
      for (int l = 0; l < W; l++) v[l*PW +: PW] = 16'h0B00;
      v[7*PW +: PW] = 16'h0A00; v[5*PW +: PW] = 16'h0A00; v[4*PW +: PW] = 16'h0C00;
      m_update(8'h00, v, 16'h0D00, 16'h0077, grp);
      do_update(8'h00, v, 16'h0D00, 16'h0077, 1'b1, cnt, dn);
      chk("R9", "busy cycles with junk request", 32'(cnt), 32'd3);
      chk("R9", "done pulse", 32'(dn), 32'd1);
      chk("R3", "top index", 32'(top_idx_o), 32'd3);
      chk("R3", "top pc", 32'(top_pc_o), 32'h0C00);
      chk("R3", "top mask", 32'(top_mask_o), 32'h10);
      chk("R6", "top rpc", 32'(top_rpc_o), 32'h0D00);
      cmp_top("R3 model");
      // pop twice to reach the first group
      do_update(8'h00, {W{16'h0D00}}, 16'h0E00, 16'h0078, 1'b0, cnt, dn);
      m_update(8'h00, {W{16'h0D00}}, 16'h0E00, 16'h0078, grp);
      chk("R3", "second group pc", 32'(top_pc_o), 32'h0B00);
      chk("R3", "second group mask", 32'(top_mask_o), 32'h4F);
      do_update(8'h00, {W{16'h0D00}}, 16'h0E00, 16'h0079, 1'b0, cnt, dn);
      m_update(8'h00, {W{16'h0D00}}, 16'h0E00, 16'h0079, grp);
      chk("R3", "first group pc", 32'(top_pc_o), 32'h0A00);
      chk("R3", "first group mask", 32'(top_mask_o), 32'hA0);
      do_update(8'h00, {W{16'h0D00}}, 16'h0E00, 16'h007A, 1'b0, cnt, dn);
      m_update(8'h00, {W{16'h0D00}}, 16'h0E00, 16'h007A, grp);
      chk("R6", "reconvergence slot pc", 32'(top_pc_o), 32'h0D00);
      chk("R6", "reconvergence slot stamp", 32'(top_stamp_o), 32'h0077);
      chk("R6", "reconvergence slot mask", 32'(top_mask_o), 32'hFF);
      cmp_top("R5 model");

      // R2: launch overrides a running update
      @(negedge clk);
      upd_i = 1'b1; upd_done_mask_i = 8'h00; upd_next_pc_i = split_pcs(8'h55, 16'h0123, 16'h0456); upd_rpc_i = 16'h0789;
      @(negedge clk);
      upd_i = 1'b0; launch_i = 1'b1; launch_pc_i = 16'h0F00; launch_mask_i = 8'h3C;
      @(negedge clk);
      launch_i = 1'b0;
      m_launch(16'h0F00, 8'h3C);
      chk("R2", "busy after abort", 32'(busy_o), 32'd0);
      cmp_top("R2 abort");

      summary();
      $finish;
   end
endmodule